// File: doc/BRIEF.md
# Interleaved Two-Bank Burst Address Mapper

This block turns a linear, byte-addressed burst into the transactions needed by a memory that is built from two 32-bit banks sitting side by side on a 64-bit bus. Consecutive 32-bit words of the linear space live in alternate banks. Address bit 2 picks the bank, and the address bits above bit 2 give the word index inside that bank. A request carries a start address, a byte count and a direction. The block then issues one bank transaction for every aligned word that the burst touches, in rising address order. Each transaction carries the bank, the in-bank word index, a 4-bit byte enable and, for writes, the data bytes moved into their lanes.

The linear space is 8 MiB. A burst that would run past the top of the space is cut short at the boundary. A burst that starts mid-word produces a partial first transaction, and a burst that ends mid-word produces a partial last one. Writes draw one beat from a source stream per transaction. Reads use the same addresses and enables but take no source data. The memory arrays are outside the block.

Top module: `vram_interleave_mapper`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1 and bank_valid, src_ready and done are 0.
- R2: The byte at linear address A (23 bits) goes out with bank_sel = A[2], bank_idx = A[22:3] and byte enable bit A[1:0]. Its data sits in bank_wdata bits 8*A[1:0]+7 down to 8*A[1:0].
- R3: A burst produces exactly one transaction per aligned 4-byte word it touches, in increasing address order, so bank_sel alternates between consecutive transactions. A partial head enables lanes from its start offset up to lane 3. A full word enables 4'hF. A partial tail enables lanes upward from lane 0.
- R4: When start + length exceeds 0x800000, the burst is shortened to end at 0x800000.
- R5: Each write transaction consumes one source beat. Segment byte k (counted from the segment's first byte) is taken from src_data[8k+7:8k].
- R6: Read requests give bank_we = 0 with the same bank, index and enables as a write, and src_ready stays 0. Write requests give bank_we = 1.
- R7: While bank_valid is 1 and bank_ready is 0, bank_sel, bank_idx and bank_be hold. A write transaction is not offered (bank_valid = 0) while src_valid is 0.
- R8: done is 1 for one cycle, one clock after the handshake of the last transaction. A zero-length request raises done one clock after it is accepted and makes no transaction.
- R9: req_ready is 0 from the cycle after a non-empty request is accepted until its last transaction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 23 | Linear start byte address |
| req_len | input | 24 | Burst length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| src_valid | input | 1 | Source write beat available |
| src_ready | output | 1 | Source beat taken this cycle when src_valid is 1 |
| src_data | input | 32 | Segment bytes, first byte in bits 7:0 |
| bank_valid | output | 1 | Bank transaction offered |
| bank_ready | input | 1 | Memory accepts the transaction |
| bank_sel | output | 1 | Bank number |
| bank_idx | output | 20 | Word index within the bank |
| bank_be | output | 4 | Byte lane enables |
| bank_wdata | output | 32 | Write data in lane position |
| bank_we | output | 1 | 1 = write transaction |
| done | output | 1 | Burst complete pulse |

## Verification
The hardest case to reach from the ports is a burst that starts in bank 1 at a mid-word offset. In that case bank 0's first index must be one above bank 1's, and the head is followed by words that alternate across both pointers. The stimulus table includes such starts: short, long and stalled. It also includes a start inside the last eight bytes of the space, where truncation and a head segment coincide. An irregular pattern of bank_ready and src_valid holds transactions mid-burst, so the hold and back-pressure behaviour is exercised while pointers are part-way through their advance.

// File: rtl/vim_pkg.sv
// Package: shared constants and helpers for the interleaved bank mapper.
// Assumes a bank word of four bytes and two banks.
package vim_pkg;
    localparam int BYTES_PER_WORD = 4;
    localparam int BANK_COUNT     = 2;

    // Contiguous byte-enable span of n lanes starting at lane off.
    function automatic logic [3:0] span_mask(input logic [1:0] off, input logic [2:0] n);
        logic [4:0] ones;
        ones = (5'd1 << n) - 5'd1;
        return ones[3:0] << off;
    endfunction
endpackage

// File: rtl/vim_req_clip.sv
// vim_req_clip: shortens a requested length so the burst stops at the top of
// the 2^ADDR_W byte space. Purely combinational; assumes LEN_W >= 1.
module vim_req_clip #(
    parameter int ADDR_W = 23,
    parameter int LEN_W  = 24
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic [LEN_W-1:0]  len_eff
);
    localparam int CW = (LEN_W > ADDR_W + 1) ? LEN_W : ADDR_W + 1;

    logic [CW-1:0] room;
    logic [CW-1:0] len_w;

    // Bytes left above the start address, and the clipped length.
    always_comb begin
        room    = (CW'(1) << ADDR_W) - CW'(addr_in);
        len_w   = CW'(len_in);
        len_eff = (len_w > room) ? LEN_W'(room) : len_in;
    end
endmodule

// File: rtl/vim_seg_calc.sv
// vim_seg_calc: sizes the next bank transaction from the current lane offset
// and the bytes still to move. Offset is non-zero only for the first segment.
module vim_seg_calc #(
    parameter int LEN_W = 24
) (
    input  logic [1:0]       off,
    input  logic [LEN_W-1:0] rem,
    output logic [2:0]       nbytes,
    output logic [3:0]       be,
    output logic             last
);
    import vim_pkg::*;

    logic [2:0] room;

    // Byte count is the smaller of what fits in the word and what remains.
    always_comb begin
        room   = 3'(BYTES_PER_WORD) - {1'b0, off};
        nbytes = (rem < LEN_W'(room)) ? rem[2:0] : room;
        be     = span_mask(off, nbytes);
        last   = (rem == LEN_W'(nbytes));
    end
endmodule

// File: rtl/vim_bank_ptrs.sv
// vim_bank_ptrs: one word pointer per bank. On load, both take the start
// word index; bank 0 is one ahead when the burst starts in bank 1. The
// selected bank's pointer steps after each of its transactions.
module vim_bank_ptrs #(
    parameter int IDX_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] base,
    input  logic             start_bank,
    input  logic             adv,
    input  logic             sel,
    output logic [IDX_W-1:0] idx_out
);
    import vim_pkg::*;

    logic [IDX_W-1:0] ptr [BANK_COUNT];

    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
        // Pointer register for bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr[b] <= '0;
            end else if (load) begin
                ptr[b] <= base + IDX_W'((b == 0) && start_bank);
            end else if (adv && (sel == 1'(b))) begin
                ptr[b] <= ptr[b] + IDX_W'(1);
            end
        end
    end

    // Present the selected bank's pointer.
    always_comb idx_out = ptr[sel];
endmodule

// File: rtl/vram_interleave_mapper.sv
// vram_interleave_mapper: maps a linear byte burst onto two interleaved
// 32-bit banks. Assumes the memory side takes one transaction per cycle at
// most and that write source beats arrive in segment order.
module vram_interleave_mapper #(
    parameter int ADDR_W = 23,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [31:0]       src_data,
    output logic              bank_valid,
    input  logic              bank_ready,
    output logic              bank_sel,
    output logic [ADDR_W-4:0] bank_idx,
    output logic [3:0]        bank_be,
    output logic [31:0]       bank_wdata,
    output logic              bank_we,
    output logic              done
);
    localparam int IDX_W = ADDR_W - 3;

    logic             busy;
    logic             cur_bank;
    logic [1:0]       off;
    logic [LEN_W-1:0] rem;
    logic             write_q;
    logic [LEN_W-1:0] len_eff;
    logic [2:0]       nbytes;
    logic             seg_last;
    logic             accept;
    logic             hs;

    vim_req_clip #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_clip (
        .addr_in (req_addr),
        .len_in  (req_len),
        .len_eff (len_eff)
    );

    vim_seg_calc #(.LEN_W(LEN_W)) u_seg (
        .off    (off),
        .rem    (rem),
        .nbytes (nbytes),
        .be     (bank_be),
        .last   (seg_last)
    );

    vim_bank_ptrs #(.IDX_W(IDX_W)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .base       (req_addr[ADDR_W-1:3]),
        .start_bank (req_addr[2]),
        .adv        (hs),
        .sel        (cur_bank),
        .idx_out    (bank_idx)
    );

    // Handshake decode and transaction outputs.
    always_comb begin
        req_ready  = !busy;
        accept     = req_valid && !busy;
        bank_valid = busy && (!write_q || src_valid);
        hs         = bank_valid && bank_ready;
        src_ready  = busy && write_q && bank_ready;
        bank_sel   = cur_bank;
        bank_we    = write_q;
        bank_wdata = write_q ? (src_data << {off, 3'b000}) : 32'h0;
    end

    // Burst state: take a request, then step segment by segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_bank <= 1'b0;
            off      <= 2'd0;
            rem      <= '0;
            write_q  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                write_q  <= req_write;
                cur_bank <= req_addr[2];
                off      <= req_addr[1:0];
                rem      <= len_eff;
                if (len_eff == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (hs) begin
                rem      <= rem - LEN_W'(nbytes);
                off      <= 2'd0;
                cur_bank <= !cur_bank;
                if (seg_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vim_checker.sv
// vim_checker: temporal checks on the mapper's ports, bound to every instance.
module vim_checker #(
    parameter int IDX_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             bank_valid,
    input logic             bank_ready,
    input logic             bank_sel,
    input logic [IDX_W-1:0] bank_idx,
    input logic [3:0]       bank_be,
    input logic             bank_we,
    input logic             src_ready,
    input logic             done
);
    // R7: a stalled transaction keeps its address and enables.
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_valid && !bank_ready && bank_we == 1'b0) |=>
        (bank_valid && $stable(bank_sel) && $stable(bank_idx) && $stable(bank_be)));

    // R9: no transaction while the block reports idle.
    a_r9_idle_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bank_valid);

    // R3: enables form one contiguous, non-empty span.
    a_r3_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        bank_valid |-> (bank_be inside {4'h1, 4'h3, 4'h7, 4'hF, 4'h2, 4'h6, 4'hE, 4'h4, 4'hC, 4'h8}));

    // R3: the bank alternates between consecutive transactions.
    a_r3_bank_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_valid && bank_ready) |=> (!bank_valid || bank_sel != $past(bank_sel)));

    // R8: completion is only reported once the block is idle.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !bank_valid));

    // R6: reads never pull source data.
    a_r6_read_no_src: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_valid && !bank_we) |-> !src_ready);
endmodule

bind vram_interleave_mapper vim_checker #(.IDX_W(ADDR_W - 3)) u_vim_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .bank_valid (bank_valid),
    .bank_ready (bank_ready),
    .bank_sel   (bank_sel),
    .bank_idx   (bank_idx),
    .bank_be    (bank_be),
    .bank_we    (bank_we),
    .src_ready  (src_ready),
    .done       (done)
);

// File: tb/sim_vram_interleave_mapper.sv
// Bench: table of bursts walked by one loop, then reset corner cases.
module sim_vram_interleave_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic        req_write = 1'b0;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic [31:0] src_data = '0;
    logic        bank_valid;
    logic        bank_ready = 1'b0;
    logic        bank_sel;
    logic [19:0] bank_idx;
    logic [3:0]  bank_be;
    logic [31:0] bank_wdata;
    logic        bank_we;
    logic        done;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    vram_interleave_mapper u0 (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] len;
        logic        wr;
        logic        stall;
        logic [7:0]  ntx;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h000000, 32'd16, 1'b1, 1'b0, 8'd4},
        '{32'h000004, 32'd8,  1'b1, 1'b1, 8'd2},
        '{32'h000001, 32'd3,  1'b1, 1'b0, 8'd1},
        '{32'h000006, 32'd11, 1'b1, 1'b1, 8'd4},
        '{32'h00000D, 32'd2,  1'b0, 1'b0, 8'd1},
        '{32'h7FFFF9, 32'd20, 1'b1, 1'b0, 8'd2},
        '{32'h3FFFFE, 32'd5,  1'b1, 1'b1, 8'd2},
        '{32'h000020, 32'd0,  1'b1, 1'b0, 8'd0},
        '{32'h000003, 32'd40, 1'b0, 1'b1, 8'd11}
    };

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] cur, rem, clip, n, expw, m;
        logic [1:0]  off;
        logic [3:0]  exp_be;
        logic        prev_stall, prev_sel;
        logic [19:0] prev_idx;
        logic [3:0]  prev_be;
        int ntx;
        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr[22:0]; req_len = v.len[23:0];
        req_write = v.wr; bank_ready = 1'b0; src_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        clip = 32'h800000 - v.addr;
        rem = (v.len > clip) ? clip : v.len;
        cur = v.addr;
        #1;
        if (rem == 0) begin
            check(done === 1'b1 && bank_valid === 1'b0, "R8 zero-length done", {done, bank_valid}, 2'b10);
            return;
        end
        check(req_ready === 1'b0, "R9 busy blocks requests", req_ready, 0);
        ntx = 0; prev_stall = 0; prev_sel = 0; prev_idx = '0; prev_be = '0;
        for (int cyc = 0; cyc < 400 && rem != 0; cyc++) begin
            if (v.stall) begin
                bank_ready = (cyc % 4 == 1) || (cyc % 4 == 2);
                src_valid  = (cyc % 4 != 1);
            end else begin
                bank_ready = 1'b1;
                src_valid  = 1'b1;
            end
            src_data = {pat(cur + 3), pat(cur + 2), pat(cur + 1), pat(cur)};
            #1;
            off = cur[1:0];
            n = ((4 - off) < rem) ? (4 - off) : rem;
            exp_be = 4'(((1 << n) - 1) << off);
            if (v.wr && !src_valid)
                check(bank_valid === 1'b0, "R7 write waits for source", bank_valid, 0);
            if (prev_stall && src_valid)
                check(bank_valid && bank_sel == prev_sel && bank_idx == prev_idx && bank_be == prev_be,
                      "R7 hold while stalled", {bank_sel, bank_idx, bank_be}, {prev_sel, prev_idx, prev_be});
            if (bank_valid && bank_ready) begin
                check(bank_sel == cur[2] && bank_idx == cur[22:3] && bank_be == exp_be,
                      "R2 R3 mapping", {bank_sel, bank_idx, bank_be}, {cur[2], cur[22:3], exp_be});
                check(bank_we == v.wr, "R6 direction", bank_we, v.wr);
                if (v.wr) begin
                    expw = '0; m = '0;
                    for (int l = 0; l < 4; l++) begin
                        if (l >= off && l < off + n) begin
                            expw[8*l +: 8] = pat(cur + 32'(l) - 32'(off));
                            m[8*l +: 8] = 8'hFF;
                        end
                    end
                    check((bank_wdata & m) == expw, "R5 lane data", bank_wdata & m, expw);
                end else begin
                    check(src_ready === 1'b0, "R6 read takes no source", src_ready, 0);
                end
                cur = cur + n; rem = rem - n; ntx++;
            end
            prev_stall = bank_valid && !bank_ready;
            prev_sel = bank_sel; prev_idx = bank_idx; prev_be = bank_be;
            @(negedge clk);
        end
        bank_ready = 1'b0; src_valid = 1'b0;
        #1;
        check(done === 1'b1 && bank_valid === 1'b0, "R8 done after last", {done, bank_valid}, 2'b10);
        if (v.len > clip)
            check(ntx == int'(v.ntx), "R4 truncated count", ntx, v.ntx);
        else
            check(ntx == int'(v.ntx), "R3 transaction count", ntx, v.ntx);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && bank_valid === 1'b0 && src_ready === 1'b0 && done === 1'b0,
              "R1 reset outputs", {req_ready, bank_valid, src_ready, done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && bank_valid === 1'b0 && done === 1'b0,
              "R1 idle after reset", {req_ready, bank_valid, done}, 3'b100);
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset in the middle of a burst returns to idle.
        @(negedge clk);
        req_valid = 1'b1; req_addr = 23'h100; req_len = 24'd64; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; src_valid = 1'b1; bank_ready = 1'b1;
        #1;
        check(req_ready === 1'b1 && bank_valid === 1'b0 && done === 1'b0,
              "R1 mid-burst reset", {req_ready, bank_valid, done}, 3'b100);
        src_valid = 1'b0; bank_ready = 1'b0;

        // R3 R8: back-to-back burst after reset, starting in bank 1 mid-word.
        run_vec('{32'h000105, 32'd9, 1'b1, 1'b0, 8'd3});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule